// File: doc/BRIEF.md
# Timestamp-Ordered Stream Merger

This block combines three hit streams into one, keeping the result in timestamp order. One stream carries hits produced locally; the other two carry hits coming from downstream readout chips, already turned into parallel words by a deserialiser. Every stream is in timestamp order on its own, and the block keeps that order across all three. Each stream has its own FIFO. On each output slot the block looks at the heads of the FIFOs, sends out the oldest hit, and removes it from its FIFO.

A stream whose FIFO is empty could still deliver an older hit, so it holds the output back. There are two ways to release such a stream. The first is a marker word sent on the stream, which raises that stream's watermark without storing a hit. The second is the watermark growing older than a set age when compared with the free-running time input. Timestamps are compared modulo their width, so the order stays correct when the counter rolls over. A hit that arrives when its FIFO is full is discarded, and that stream's loss counter goes up by one.

Top module: `ts_merge_top`

## Requirements
- R1: Hits accepted at the output appear in non-decreasing timestamp order, as long as every input stream is itself ordered.
- R2: The output word is the head with the oldest timestamp among the non-empty FIFOs. When timestamps are equal, the stream index decides: local (index 0) first, then child 0 (index 1), then child 1 (index 2).
- R3: Timestamps occupy the top TS_W bits of a word. A is older than B when bit TS_W-1 of (A-B) mod 2^TS_W is set, so 250 is older than 3 when TS_W is 8.
- R4: While some stream has an empty FIFO and is not released, out_valid stays low.
- R5: An input word with its mark bit set is not stored. It sets that stream's watermark. An empty stream is released when the selected head is strictly older than its watermark; an equal watermark does not release it.
- R6: An empty stream is also released when (now_ts - watermark) mod 2^TS_W has its top bit clear and is greater than AGE_LIMIT. Exactly AGE_LIMIT does not release it. Hits update the watermark too.
- R7: A hit that arrives when its FIFO is full is dropped. The loss counter of that stream (field i of loss_cnt) goes up by one, and the hits already stored are kept.
- R8: A hit is removed only in a cycle where out_valid and out_ready are both high. While out_ready is low, out_valid and out_word stay unchanged.
- R9: After reset all FIFOs are empty, every watermark is zero, out_valid is low and every loss counter is zero.
- R10: The local FIFO holds LOC_DEPTH hits and each child FIFO holds CH_DEPTH hits (16 and 256 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| now_ts | input | TS_W | Free-running time used for the age release |
| in_valid | input | 3 | Word present, one bit per stream (0 local, 1 child 0, 2 child 1) |
| in_mark | input | 3 | Word is a marker, not a hit |
| in_word | input | 3*WORD_W | Input words, stream i at bits i*WORD_W and up |
| out_valid | output | 1 | Output hit available |
| out_ready | input | 1 | Downstream accepts the output hit |
| out_word | output | WORD_W | Oldest hit |
| loss_cnt | output | 3*CNT_W | Per-stream count of dropped hits |

## Verification
The ordering property assumes that each stream sends non-decreasing timestamps, including its markers. It also assumes that a released stream never later sends a hit older than one already forwarded, and that all live timestamps stay within half the counter range of each other. The bench meets these assumptions in three ways. It loads each stream with a rising sequence, closes it with a marker newer than every hit, and only then raises out_ready. It keeps now_ts at zero except in the age scenario, where the single stored hit is the only traffic. Sweep patterns place the time base near the top of the counter range so that the rollover is exercised without breaking the half-range assumption.

// File: rtl/ts_merge_pkg.sv
package ts_merge_pkg;
   localparam int NUM_SRC = 3;   // local stream plus two child streams
   localparam int LOC_IDX = 0;   // index of the local stream; wins ties
endpackage

// File: rtl/ts_merge_fifo.sv
module ts_merge_fifo #(
   parameter int W     = 48,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("ts_merge_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   fill;
   logic          do_push, do_pop;

   assign empty   = (fill == '0);
   assign full    = (fill == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
      end
   end
endmodule

// File: rtl/ts_merge_lane.sv
module ts_merge_lane #(
   parameter int W         = 48,
   parameter int TS_W      = 16,
   parameter int DEPTH     = 16,
   parameter int CNT_W     = 16,
   parameter int AGE_LIMIT = 1000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [TS_W-1:0] now_ts,
   input  logic            in_valid,
   input  logic            in_mark,
   input  logic [W-1:0]    in_word,
   input  logic            pop,
   output logic [W-1:0]    head,
   output logic            nonempty,
   output logic [TS_W-1:0] wmark,
   output logic            expired,
   output logic [CNT_W-1:0] loss
);
   logic            hit, full, empty;
   logic [TS_W-1:0] age;

   assign hit = in_valid && !in_mark;

   ts_merge_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(hit), .din(in_word), .pop(pop),
      .dout(head), .empty(empty), .full(full)
   );

   assign nonempty = !empty;

   // watermark: newest timestamp seen on this stream, hit or marker
   always_ff @(posedge clk) begin
      if (rst) begin
         wmark <= '0;
         loss  <= '0;
      end else begin
         if (in_valid) wmark <= in_word[W-1 -: TS_W];
         if (hit && full) loss <= loss + CNT_W'(1);
      end
   end

   // age release: watermark behind current time by more than the limit
   assign age     = now_ts - wmark;
   assign expired = !age[TS_W-1] && (age > TS_W'(AGE_LIMIT));
endmodule

// File: rtl/ts_merge_pick.sv
module ts_merge_pick #(
   parameter int N    = 3,
   parameter int W    = 48,
   parameter int TS_W = 16
) (
   input  logic [N*W-1:0]    heads,
   input  logic [N*TS_W-1:0] head_ts,
   input  logic [N-1:0]      nonempty,
   input  logic [N*TS_W-1:0] wmarks,
   input  logic [N-1:0]      expired,
   output logic              out_valid,
   output logic [W-1:0]      out_word,
   output logic [N-1:0]      sel
);
   function automatic logic older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
      logic [TS_W-1:0] d;
      d = a - b;
      return d[TS_W-1];
   endfunction

   logic            found, blocked;
   logic [TS_W-1:0] best_ts;

   always_comb begin
      found    = 1'b0;
      blocked  = 1'b0;
      best_ts  = '0;
      out_word = '0;
      sel      = '0;
      // strict comparison: on equal timestamps the lower index is kept
      for (int i = 0; i < N; i++) begin
         if (nonempty[i] && (!found || older(head_ts[i*TS_W +: TS_W], best_ts))) begin
            found    = 1'b1;
            best_ts  = head_ts[i*TS_W +: TS_W];
            out_word = heads[i*W +: W];
            sel      = '0;
            sel[i]   = 1'b1;
         end
      end
      for (int j = 0; j < N; j++) begin
         if (!nonempty[j] && !expired[j] && !older(best_ts, wmarks[j*TS_W +: TS_W]))
            blocked = 1'b1;
      end
   end

   assign out_valid = found && !blocked;
endmodule

// File: rtl/ts_merge_top.sv
module ts_merge_top
   import ts_merge_pkg::*;
#(
   parameter int WORD_W    = 48,
   parameter int TS_W      = 16,
   parameter int LOC_DEPTH = 16,
   parameter int CH_DEPTH  = 256,
   parameter int CNT_W     = 16,
   parameter int AGE_LIMIT = 1000
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [TS_W-1:0]           now_ts,
   input  logic [NUM_SRC-1:0]        in_valid,
   input  logic [NUM_SRC-1:0]        in_mark,
   input  logic [NUM_SRC*WORD_W-1:0] in_word,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [WORD_W-1:0]         out_word,
   output logic [NUM_SRC*CNT_W-1:0]  loss_cnt
);
   if (TS_W >= WORD_W) begin : g_bad_ts
      $error("ts_merge_top: TS_W must leave room for payload");
   end
   if (AGE_LIMIT >= (1 << (TS_W-1))) begin : g_bad_age
      $error("ts_merge_top: AGE_LIMIT must be below half the timestamp range");
   end

   logic [NUM_SRC*WORD_W-1:0] lane_head;
   logic [NUM_SRC*TS_W-1:0]   lane_ts;
   logic [NUM_SRC*TS_W-1:0]   lane_wm;
   logic [NUM_SRC-1:0]        lane_ne, lane_exp, lane_sel, lane_pop;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
      localparam int D = (g == LOC_IDX) ? LOC_DEPTH : CH_DEPTH;

      ts_merge_lane #(
         .W(WORD_W), .TS_W(TS_W), .DEPTH(D), .CNT_W(CNT_W), .AGE_LIMIT(AGE_LIMIT)
      ) u_lane (
         .clk      (clk),
         .rst      (rst),
         .now_ts   (now_ts),
         .in_valid (in_valid[g]),
         .in_mark  (in_mark[g]),
         .in_word  (in_word[g*WORD_W +: WORD_W]),
         .pop      (lane_pop[g]),
         .head     (lane_head[g*WORD_W +: WORD_W]),
         .nonempty (lane_ne[g]),
         .wmark    (lane_wm[g*TS_W +: TS_W]),
         .expired  (lane_exp[g]),
         .loss     (loss_cnt[g*CNT_W +: CNT_W])
      );

      assign lane_ts[g*TS_W +: TS_W] = lane_head[g*WORD_W + WORD_W - 1 -: TS_W];
      assign lane_pop[g]             = out_valid && out_ready && lane_sel[g];
   end

   ts_merge_pick #(.N(NUM_SRC), .W(WORD_W), .TS_W(TS_W)) u_pick (
      .heads     (lane_head),
      .head_ts   (lane_ts),
      .nonempty  (lane_ne),
      .wmarks    (lane_wm),
      .expired   (lane_exp),
      .out_valid (out_valid),
      .out_word  (out_word),
      .sel       (lane_sel)
   );
endmodule

// File: rtl/ts_merge_chk.sv
module ts_merge_chk #(
   parameter int N     = 3,
   parameter int TS_W  = 16,
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              out_valid,
   input logic              out_ready,
   input logic [TS_W-1:0]   out_ts,
   input logic [N*TS_W-1:0] lane_ts,
   input logic [N-1:0]      lane_ne,
   input logic [N*CNT_W-1:0] loss_cnt
);
   function automatic logic older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
      logic [TS_W-1:0] d;
      d = a - b;
      return d[TS_W-1];
   endfunction

   logic            rst_q, has_last;
   logic [TS_W-1:0] last_ts;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q === 1'b1 && rst === 1'b0) begin
         // R9: state cleared on leaving reset
         a_r9_reset_clear: assert (loss_cnt == '0 && !out_valid)
            else $error("R9: state not clear after reset");
      end
      if (rst) begin
         has_last <= 1'b0;
         last_ts  <= '0;
      end else if (out_valid && out_ready) begin
         has_last <= 1'b1;
         last_ts  <= out_ts;
      end
   end

   // R1: accepted timestamps never step backwards
   a_r1_order: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && has_last) |-> !older(out_ts, last_ts));

   // R4: a valid output always comes from a stored hit
   a_r4_source: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (lane_ne != '0));

   for (genvar j = 0; j < N; j++) begin : g_chk
      // R2: no non-empty head is older than the forwarded hit
      a_r2_oldest: assert property (@(posedge clk) disable iff (rst)
         (out_valid && lane_ne[j]) |-> !older(lane_ts[j*TS_W +: TS_W], out_ts));
      // R7: each loss counter advances by at most one per cycle
      a_r7_loss_step: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (loss_cnt[j*CNT_W +: CNT_W] == $past(loss_cnt[j*CNT_W +: CNT_W]) ||
                   loss_cnt[j*CNT_W +: CNT_W] == $past(loss_cnt[j*CNT_W +: CNT_W]) + CNT_W'(1)));
   end
endmodule

bind ts_merge_top ts_merge_chk #(.N(3), .TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_ts    (out_word[WORD_W-1 -: TS_W]),
   .lane_ts   (lane_ts),
   .lane_ne   (lane_ne),
   .loss_cnt  (loss_cnt)
);

// File: tb/ts_merge_top_bench.sv
module ts_merge_top_bench;
   localparam int WW = 24, TW = 8, CW = 8, NS = 3;

   logic           clk = 1'b0;
   logic           rst;
   logic [TW-1:0]  now_ts;
   logic [NS-1:0]  in_valid, in_mark;
   logic [NS*WW-1:0] in_word;
   logic           out_valid, out_ready;
   logic [WW-1:0]  out_word;
   logic [NS*CW-1:0] loss_cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [WW-1:0] qw [NS][10];
   int            qk [NS];
   logic [WW-1:0] ew [32];
   int            en;

   ts_merge_top #(.WORD_W(WW), .TS_W(TW), .LOC_DEPTH(4), .CH_DEPTH(8),
                  .CNT_W(CW), .AGE_LIMIT(20)) u_ts_merge_top (
      .clk(clk), .rst(rst), .now_ts(now_ts), .in_valid(in_valid), .in_mark(in_mark),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .loss_cnt(loss_cnt));

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit older8(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] d;
      d = a - b;
      return d[7];
   endfunction

   task automatic do_reset();
      rst = 1'b1; in_valid = '0; in_mark = '0; in_word = '0;
      out_ready = 1'b0; now_ts = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic send(input int i, input bit mark, input logic [WW-1:0] w);
      in_valid = '0; in_mark = '0;
      in_valid[i] = 1'b1; in_mark[i] = mark; in_word[i*WW +: WW] = w;
      @(negedge clk);
      in_valid = '0; in_mark = '0;
   endtask

   function automatic logic [WW-1:0] mk(input logic [7:0] ts, input int i, input int n);
      return {ts, 8'(i), 8'(n)};
   endfunction

   task automatic push_queues(input logic [7:0] mts);
      for (int n = 0; n < 10; n++) begin
         bit any = 0;
         in_valid = '0; in_mark = '0;
         for (int i = 0; i < NS; i++)
            if (n < qk[i]) begin
               in_valid[i] = 1'b1; in_word[i*WW +: WW] = qw[i][n]; any = 1;
            end
         if (any) @(negedge clk);
      end
      in_valid = '1; in_mark = '1;
      for (int i = 0; i < NS; i++) in_word[i*WW +: WW] = {mts, 16'h0};
      @(negedge clk);
      in_valid = '0; in_mark = '0;
   endtask

   // expected merge: oldest head first, lower stream index on equal stamps
   task automatic build_exp();
      int hd[NS];
      for (int i = 0; i < NS; i++) hd[i] = 0;
      en = 0;
      forever begin
         bit found = 0; int bi = 0; logic [7:0] bt = '0;
         for (int i = 0; i < NS; i++)
            if (hd[i] < qk[i] && (!found || older8(qw[i][hd[i]][23:16], bt))) begin
               found = 1; bi = i; bt = qw[i][hd[i]][23:16];
            end
         if (!found) break;
         ew[en] = qw[bi][hd[bi]]; en++; hd[bi]++;
      end
   endtask

   task automatic drain(input string tag);
      out_ready = 1'b1;
      for (int k = 0; k < en; k++) begin
         check(out_valid == 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
         check(out_word == ew[k], {tag, " word"}, 32'(out_word), 32'(ew[k]));
         @(negedge clk);
      end
      out_ready = 1'b0;
      check(out_valid == 1'b0, {tag, " idle after drain"}, 32'(out_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [WW-1:0] held;
      // R9: reset state
      do_reset();
      check(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'd0);
      check(loss_cnt == '0, "R9 loss after reset", 32'(loss_cnt), 32'd0);

      // R4 / R5: blocking and marker release
      send(0, 1'b0, mk(8'd5, 0, 0));
      check(out_valid == 1'b0, "R4 blocked by empty children", 32'(out_valid), 32'd0);
      send(1, 1'b1, {8'd10, 16'h0});
      check(out_valid == 1'b0, "R4 blocked by child 1", 32'(out_valid), 32'd0);
      send(2, 1'b1, {8'd5, 16'h0});
      check(out_valid == 1'b0, "R5 equal marker keeps block", 32'(out_valid), 32'd0);
      send(2, 1'b1, {8'd6, 16'h0});
      check(out_valid == 1'b1, "R5 newer marker releases", 32'(out_valid), 32'd1);
      check(out_word == mk(8'd5, 0, 0), "R5 released word", 32'(out_word), 32'(mk(8'd5, 0, 0)));

      // R2: equal stamps on all streams resolve by stream index
      do_reset();
      for (int i = 0; i < NS; i++) begin qk[i] = 1; qw[i][0] = mk(8'd9, i, 0); end
      push_queues(8'd50);
      build_exp();
      drain("R2 tie order");

      // R3: rollover ordering, 250 older than 3
      do_reset();
      qk[0] = 1; qw[0][0] = mk(8'd250, 0, 0);
      qk[1] = 1; qw[1][0] = mk(8'd3, 1, 0);
      qk[2] = 0;
      push_queues(8'd20);
      check(out_word == mk(8'd250, 0, 0), "R3 wrap head", 32'(out_word), 32'(mk(8'd250, 0, 0)));
      build_exp();
      drain("R3 wrap drain");

      // R1 / R2 / R3: sweep of stream patterns, some across rollover
      for (int p = 0; p < 6; p++) begin
         logic [7:0] base;
         base = 8'((p * 50) % 256);
         do_reset();
         for (int i = 0; i < NS; i++) begin
            int st, sp;
            qk[i] = (i == 0) ? 1 + (p % 4) : 1 + ((p * 3 + i) % 8);
            st = (p * 5 + i * 3) % 11;
            sp = (p + i) % 3;
            for (int n = 0; n < qk[i]; n++) qw[i][n] = mk(base + 8'(st + n * sp), i, n);
         end
         push_queues(base + 8'd100);
         build_exp();
         drain("R1 sweep merge order");
      end

      // R7 / R10: overflow drops newest hits and counts them
      do_reset();
      qk[0] = 5; qk[1] = 9; qk[2] = 0;
      for (int n = 0; n < 10; n++) begin
         qw[0][n] = mk(8'(n + 1), 0, n);
         qw[1][n] = mk(8'(n + 1), 1, n);
      end
      push_queues(8'd50);
      check(loss_cnt[0*CW +: CW] == 8'd1, "R7 local loss", 32'(loss_cnt[0*CW +: CW]), 32'd1);
      check(loss_cnt[1*CW +: CW] == 8'd1, "R7 child0 loss", 32'(loss_cnt[1*CW +: CW]), 32'd1);
      check(loss_cnt[2*CW +: CW] == 8'd0, "R7 child1 no loss", 32'(loss_cnt[2*CW +: CW]), 32'd0);
      qk[0] = 4; qk[1] = 8;
      build_exp();
      drain("R10 depth-limited drain");

      // R6 / R8: age release boundary and handshake hold
      do_reset();
      send(0, 1'b0, mk(8'd2, 0, 7));
      now_ts = 8'd20;
      @(negedge clk);
      check(out_valid == 1'b0, "R6 age equal limit blocks", 32'(out_valid), 32'd0);
      now_ts = 8'd21;
      @(negedge clk);
      check(out_valid == 1'b1, "R6 age beyond limit releases", 32'(out_valid), 32'd1);
      held = out_word;
      check(held == mk(8'd2, 0, 7), "R6 released word", 32'(held), 32'(mk(8'd2, 0, 7)));
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check(out_valid == 1'b1 && out_word == held, "R8 hold while not ready",
               32'(out_word), 32'(held));
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(out_valid == 1'b0, "R8 single pop on accept", 32'(out_valid), 32'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule